// File: doc/BRIEF.md
# Ripple Bit-Slice Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit with a default operand width of eight bits. It is assembled from a chain of identical one-bit slices joined by a ripple carry. A three-bit operation code selects one of seven functions. Four are bitwise logic functions (AND, OR, NAND, NOR). Two are two's-complement addition and subtraction. The last is a signed set-on-less-than that returns 1 or 0 in the least significant bit. Subtraction and the comparison share the adder: every slice inverts its b operand and the carry into the lowest slice is forced to 1.

The top slice differs from the others. It also derives the signed overflow of the chain by comparing the carry into the top bit with the carry out of it. It also forms a corrected sign, which is the sum's sign bit XOR that overflow. The corrected sign is routed back to the lowest slice as its "less" input, so the comparison is right even when the internal difference overflows. The result and the flag follow the inputs with no clock and no state. Op code 7 is not used by callers, and this design returns zero for it.

Top module: `salu_top`

## Requirements
- R1: Op code 0 drives result_o with the bitwise AND of a_i and b_i.
- R2: Op code 1 drives result_o with the bitwise OR of a_i and b_i.
- R3: Op code 2 drives result_o with the bitwise NAND of a_i and b_i.
- R4: Op code 3 drives result_o with the bitwise NOR of a_i and b_i.
- R5: Op code 4 drives result_o with (a_i + b_i) modulo 2^WIDTH.
- R6: Op code 5 drives result_o with (a_i - b_i) modulo 2^WIDTH.
- R7: Under op code 4, overflow_o is 1 exactly when the true signed sum of a_i and b_i falls outside the signed WIDTH-bit range.
- R8: Under op code 5, overflow_o is 1 exactly when the true signed difference a_i - b_i falls outside the signed WIDTH-bit range.
- R9: Op code 6 drives result_o with the value 1 when a_i is less than b_i as signed two's-complement numbers, and with 0 otherwise, including operand pairs whose difference overflows. All bits above bit 0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code: 0 AND, 1 OR, 2 NAND, 3 NOR, 4 add, 5 subtract, 6 signed less-than |
| result_o | output | WIDTH | Operation result |
| overflow_o | output | 1 | Signed overflow, meaningful for op codes 4 and 5 only |

## Verification
The bench targets the operand extremes 8'h00, 8'h01, 8'h7F, 8'h80, 8'h81 and 8'hFF in every pairing and with every op code. This exposes a ripple chain whose carry into the top bit is wrong: such a design would flag overflow on additions like 8'h7F + 8'hFF that do not overflow, or miss it on 8'h7F + 8'h01. The comparison is driven with pairs such as 8'h80 against 8'h7F, where the difference overflows. A design that fed back the raw sign bit instead of the corrected one would report "not less" there. Logic operations run with b patterns that would be altered if the subtract-side inversion leaked into them.

// File: rtl/salu_pkg.sv
package salu_pkg;

   // Operation encoding seen at the block edge
   typedef enum logic [2:0] {
      OP_AND  = 3'd0,
      OP_OR   = 3'd1,
      OP_NAND = 3'd2,
      OP_NOR  = 3'd3,
      OP_ADD  = 3'd4,
      OP_SUB  = 3'd5,
      OP_SLT  = 3'd6,
      OP_RSV  = 3'd7
   } alu_op_e;

   // Output selection inside each slice
   typedef enum logic [2:0] {
      SEL_AND  = 3'd0,
      SEL_OR   = 3'd1,
      SEL_NAND = 3'd2,
      SEL_NOR  = 3'd3,
      SEL_SUM  = 3'd4,
      SEL_LESS = 3'd5,
      SEL_ZERO = 3'd6
   } slice_sel_e;

endpackage

// File: rtl/salu_ctl_decode.sv
module salu_ctl_decode
   import salu_pkg::*;
(
   input  logic [2:0] op_i,
   output slice_sel_e sel_o,
   output logic       b_inv_o,
   output logic       carry0_o
);

   always_comb begin
      sel_o    = SEL_ZERO;
      b_inv_o  = 1'b0;
      carry0_o = 1'b0;
      unique case (alu_op_e'(op_i))
         OP_AND:  sel_o = SEL_AND;
         OP_OR:   sel_o = SEL_OR;
         OP_NAND: sel_o = SEL_NAND;
         OP_NOR:  sel_o = SEL_NOR;
         OP_ADD:  sel_o = SEL_SUM;
         OP_SUB: begin
            sel_o    = SEL_SUM;
            b_inv_o  = 1'b1;
            carry0_o = 1'b1;
         end
         OP_SLT: begin
            sel_o    = SEL_LESS;
            b_inv_o  = 1'b1;
            carry0_o = 1'b1;
         end
         default: sel_o = SEL_ZERO;
      endcase
   end

endmodule

// File: rtl/salu_bit_slice.sv
module salu_bit_slice
   import salu_pkg::*;
(
   input  logic       a_i,
   input  logic       b_i,
   input  logic       carry_i,
   input  logic       less_i,
   input  logic       b_inv_i,
   input  slice_sel_e sel_i,
   output logic       result_o,
   output logic       carry_o
);

   logic       b_eff;
   logic [1:0] add_w;

   // The inverted operand feeds the adder only; logic functions see raw b
   assign b_eff   = b_i ^ b_inv_i;
   assign add_w   = {1'b0, a_i} + {1'b0, b_eff} + {1'b0, carry_i};
   assign carry_o = add_w[1];

   always_comb begin
      unique case (sel_i)
         SEL_AND:  result_o = a_i & b_i;
         SEL_OR:   result_o = a_i | b_i;
         SEL_NAND: result_o = ~(a_i & b_i);
         SEL_NOR:  result_o = ~(a_i | b_i);
         SEL_SUM:  result_o = add_w[0];
         SEL_LESS: result_o = less_i;
         default:  result_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/salu_msb_slice.sv
module salu_msb_slice
   import salu_pkg::*;
(
   input  logic       a_i,
   input  logic       b_i,
   input  logic       carry_i,
   input  logic       less_i,
   input  logic       b_inv_i,
   input  slice_sel_e sel_i,
   output logic       result_o,
   output logic       set_o,
   output logic       ovf_o
);

   logic cout_w;
   logic sign_w;

   salu_bit_slice u_core (
      .a_i      (a_i),
      .b_i      (b_i),
      .carry_i  (carry_i),
      .less_i   (less_i),
      .b_inv_i  (b_inv_i),
      .sel_i    (sel_i),
      .result_o (result_o),
      .carry_o  (cout_w)
   );

   // Raw sign of the sum, then corrected by the overflow indication
   assign sign_w = a_i ^ (b_i ^ b_inv_i) ^ carry_i;
   assign ovf_o  = carry_i ^ cout_w;
   assign set_o  = sign_w ^ ovf_o;

endmodule

// File: rtl/salu_top.sv
module salu_top
   import salu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [2:0]       op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             overflow_o
);

   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_chk
      $error("salu_top: WIDTH must be at least 2");
   end

   slice_sel_e sel_w;
   logic       b_inv_w;
   logic       carry0_w;
   logic       set_w;
   logic       ovf_w;

   salu_ctl_decode u_dec (
      .op_i     (op_i),
      .sel_o    (sel_w),
      .b_inv_o  (b_inv_w),
      .carry0_o (carry0_w)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : stage
      logic cin_w;
      logic less_w;

      if (i == 0) begin : g_head
         assign cin_w  = carry0_w;
         assign less_w = set_w;
      end else begin : g_link
         assign cin_w  = stage[i-1].g_body.cout_w;
         assign less_w = 1'b0;
      end

      if (i < TOP) begin : g_body
         logic cout_w;
         salu_bit_slice u_slice (
            .a_i      (a_i[i]),
            .b_i      (b_i[i]),
            .carry_i  (cin_w),
            .less_i   (less_w),
            .b_inv_i  (b_inv_w),
            .sel_i    (sel_w),
            .result_o (result_o[i]),
            .carry_o  (cout_w)
         );
      end else begin : g_msb
         salu_msb_slice u_slice (
            .a_i      (a_i[i]),
            .b_i      (b_i[i]),
            .carry_i  (cin_w),
            .less_i   (less_w),
            .b_inv_i  (b_inv_w),
            .sel_i    (sel_w),
            .result_o (result_o[i]),
            .set_o    (set_w),
            .ovf_o    (ovf_w)
         );
      end
   end

   assign overflow_o = ovf_w;

endmodule

// File: rtl/salu_checker.sv
module salu_checker #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic [2:0]       op,
   input logic [WIDTH-1:0] result,
   input logic             ovf
);

   logic [WIDTH:0] add_ext;
   logic [WIDTH:0] sub_ext;

   // Sign-extended wide arithmetic, independent of the carry chain
   assign add_ext = {a[WIDTH-1], a} + {b[WIDTH-1], b};
   assign sub_ext = {a[WIDTH-1], a} - {b[WIDTH-1], b};

   always_comb begin
      if (!$isunknown({a, b, op, result, ovf})) begin
         if (op == 3'd0) assert_and_R1 : assert (result == (a & b));
         if (op == 3'd1) assert_or_R2 : assert (result == (a | b));
         if (op == 3'd2) assert_nand_R3 : assert (result == ~(a & b));
         if (op == 3'd3) assert_nor_R4 : assert (result == ~(a | b));
         if (op == 3'd4) assert_add_R5 : assert (result == add_ext[WIDTH-1:0]);
         if (op == 3'd5) assert_sub_R6 : assert (result == sub_ext[WIDTH-1:0]);
         if (op == 3'd4) assert_add_ovf_R7 : assert (ovf == (add_ext[WIDTH] != add_ext[WIDTH-1]));
         if (op == 3'd5) assert_sub_ovf_R8 : assert (ovf == (sub_ext[WIDTH] != sub_ext[WIDTH-1]));
         if (op == 3'd6) assert_slt_R9 : assert (result == {{(WIDTH-1){1'b0}}, sub_ext[WIDTH]});
      end
   end

endmodule

bind salu_top salu_checker #(.WIDTH(WIDTH)) u_chk (
   .a      (a_i),
   .b      (b_i),
   .op     (op_i),
   .result (result_o),
   .ovf    (overflow_o)
);

// File: tb/salu_top_tb_top.sv
`timescale 1ns/1ps
module salu_top_tb_top;

   localparam int W        = 8;
   localparam int WD_LIMIT = 20000;

   logic         clk = 1'b0;
   logic [W-1:0] a, b;
   logic [2:0]   op;
   logic [W-1:0] result;
   logic         ovf;
   int           checks = 0;
   int           errors = 0;
   int           cycles = 0;
   bit           done   = 0;

   always #2.5 clk = ~clk;

   salu_top #(.WIDTH(W)) dut_i (
      .a_i        (a),
      .b_i        (b),
      .op_i       (op),
      .result_o   (result),
      .overflow_o (ovf)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WD_LIMIT && !done) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic string res_tag(input logic [2:0] o);
      case (o)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         default: return "R9";
      endcase
   endfunction

   // Behavioural reference on signed integers
   task automatic expect_vals(input logic [W-1:0] va, vb, input logic [2:0] vo,
                              output logic [W-1:0] er, output logic eo);
      int sa, sb, t;
      sa = int'($signed(va));
      sb = int'($signed(vb));
      eo = 1'b0;
      case (vo)
         3'd0: er = va & vb;
         3'd1: er = va | vb;
         3'd2: er = ~(va & vb);
         3'd3: er = ~(va | vb);
         3'd4: begin t = sa + sb; er = t[W-1:0]; eo = (t > 127) || (t < -128); end
         3'd5: begin t = sa - sb; er = t[W-1:0]; eo = (t > 127) || (t < -128); end
         default: er = (sa < sb) ? 8'h01 : 8'h00;
      endcase
   endtask

   task automatic run_vec(input logic [W-1:0] va, vb, input logic [2:0] vo);
      logic [W-1:0] er;
      logic         eo;
      @(posedge clk);
      a = va; b = vb; op = vo;
      @(negedge clk);
      expect_vals(va, vb, vo, er, eo);
      checks++;
      if (result !== er) begin
         errors++;
         $display("FAIL %s: a=%h b=%h op=%0d result actual %h expected %h",
                  res_tag(vo), va, vb, vo, result, er);
      end
      if (vo == 3'd4 || vo == 3'd5) begin
         checks++;
         if (ovf !== eo) begin
            errors++;
            $display("FAIL %s: a=%h b=%h overflow actual %b expected %b",
                     (vo == 3'd4) ? "R7" : "R8", va, vb, ovf, eo);
         end
      end
   endtask

   initial begin
      logic [W-1:0] corners[$];
      corners = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF, 8'h40, 8'hC0};
      a = '0; b = '0; op = 3'd0;

      // Idle state: zero operands with AND give zero (R1)
      run_vec(8'h00, 8'h00, 3'd0);

      // Directed overflow cases: R7 add, R8 subtract, R9 compare
      run_vec(8'h7F, 8'h01, 3'd4);
      run_vec(8'h80, 8'hFF, 3'd4);
      run_vec(8'h7F, 8'hFF, 3'd4);
      run_vec(8'h80, 8'h01, 3'd5);
      run_vec(8'h7F, 8'hFF, 3'd5);
      run_vec(8'h00, 8'h80, 3'd5);
      run_vec(8'h80, 8'h7F, 3'd6);
      run_vec(8'h7F, 8'h80, 3'd6);
      run_vec(8'hFF, 8'h00, 3'd6);
      run_vec(8'h05, 8'h05, 3'd6);

      // Logic ops with patterns that expose a leaking b inversion (R1-R4 each)
      run_vec(8'hA5, 8'h0F, 3'd0);
      run_vec(8'hA5, 8'h0F, 3'd1);
      run_vec(8'hA5, 8'h0F, 3'd2);
      run_vec(8'hA5, 8'h0F, 3'd3);

      // Every corner pairing under every op code
      foreach (corners[i])
         foreach (corners[j])
            for (int o = 0; o < 7; o++)
               run_vec(corners[i], corners[j], 3'(o));

      // Random operands and op codes
      for (int n = 0; n < 3000; n++)
         run_vec(8'($urandom), 8'($urandom), 3'($urandom_range(6, 0)));

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule